// File: doc/BRIEF.md
# Debug Command Byte Interpreter

This block sits behind the serial link of an on-chip debug port and turns a stream of host bytes into register accesses. Each command starts with a one-byte opcode. Depending on the opcode, the interpreter either takes a fixed number of payload bytes from the host or sends back a fixed number of response bytes. Both directions use valid/ready byte streams.

The registers it serves are:

- a revision constant;
- a 16-bit debug counter;
- a status byte;
- a test-mode byte;
- a small bank of option bytes.

A debug-mode input controls access to the counter. Two protection inputs do two jobs: both are reported in the status byte, and the write-protect input stops test mode from being switched on. Bits marked as protected in the option bank can never be changed by a command.

Top module: `dbg_cmd_interp`

## Requirements
- R1: After reset, `in_ready_o` is high and `out_valid_o` is low. Reset clears the counter, test-mode and status registers and loads the option bytes with `OPT_RESET` (default byte 0 = C3h, byte 1 = 12h).
- R2: Opcode 00h returns two bytes: `REV_ID[15:8]`, then `REV_ID[7:0]` (default 01h, then 03h).
- R3: Opcode 01h takes two payload bytes, high byte first, and loads them into the counter. This happens only if `debug_mode_i` was high when the opcode was accepted. Otherwise both bytes are consumed and the counter keeps its value.
- R4: Opcode 02h returns the status byte. Its bits are:
  - bit 7: `debug_mode_i`;
  - bit 6: `rd_prot_i`;
  - bit 5: `info_wp_i`;
  - bit 4: test-mode bit 0;
  - bits 3:0: zero.
  The values are those registered one cycle before the opcode is accepted.
- R5: Opcode 03h returns two bytes: the bit-inverted counter high byte, then the bit-inverted low byte. If `debug_mode_i` is low when the opcode is accepted, it returns FFh, FFh instead.
- R6: Opcode F0h writes its one payload byte to the test-mode register, and F1h returns that register. Bit 0 is the test enable. While `info_wp_i` is high, a write cannot change bit 0 from 0 to 1; it may still clear bit 0, and the other bits are written normally.
- R7: Opcode F2h takes `OPT_BYTES` payload bytes, byte 0 first, and writes them to the option bank. Bits set in `OPT_PROT_MASK` keep their old value; by default these are bits 7 and 6 of byte 0. Opcode F3h returns the option bytes, byte 0 first.
- R8: Any other opcode produces no response and changes no register, and `in_ready_o` stays high.
- R9: A response byte holds `out_valid_o` and `out_data_o` steady until `out_ready_i` accepts it. `in_ready_o` is low from the cycle after a read opcode is accepted until the last response byte has been accepted.
- R10: The first response byte is valid in the cycle after its opcode is accepted. A write is visible to a read opcode accepted in the cycle right after the last payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| debug_mode_i | input | 1 | Device is in debug mode |
| rd_prot_i | input | 1 | Read-protect state |
| info_wp_i | input | 1 | Information-area write-protect state |
| in_valid_i | input | 1 | Host byte valid |
| in_data_i | input | 8 | Host byte |
| in_ready_o | output | 1 | Interpreter accepts a host byte |
| out_valid_o | output | 1 | Response byte valid |
| out_data_o | output | 8 | Response byte |
| out_ready_i | input | 1 | Host accepts the response byte |

## Verification
A wrong sequencer state appears at the ports in the same cycle:
- `in_ready_o` and `out_valid_o` disagree with the expected phase;
- a byte is sent that should not be, or a byte is skipped.

The bench therefore compares both handshake outputs and the data byte against a queue model on every falling edge. A corrupted register value stays hidden until the next read opcode for that register. The stimulus therefore reads back every register after each write, after each blocked write and after each reserved opcode. Backpressure phases test whether the held byte stays stable across stalled cycles.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam logic [7:0] OP_REV_RD  = 8'h00;
  localparam logic [7:0] OP_CNT_WR  = 8'h01;
  localparam logic [7:0] OP_STAT_RD = 8'h02;
  localparam logic [7:0] OP_CNT_RD  = 8'h03;
  localparam logic [7:0] OP_TEST_WR = 8'hF0;
  localparam logic [7:0] OP_TEST_RD = 8'hF1;
  localparam logic [7:0] OP_OPT_WR  = 8'hF2;
  localparam logic [7:0] OP_OPT_RD  = 8'hF3;

  localparam int CNT_W   = 16;
  localparam int TEST_EN = 0;

  typedef enum logic [1:0] {KIND_NONE, KIND_READ, KIND_WRITE} cmd_kind_e;
  typedef enum logic [2:0] {TGT_REV, TGT_STAT, TGT_CNT, TGT_TEST, TGT_OPT} cmd_tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} cmd_st_e;

  typedef struct packed {
    cmd_kind_e kind;
    cmd_tgt_e  tgt;
  } cmd_dec_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
#(
  parameter int OPT_BYTES = 2,
  parameter int LEN_W     = 2
) (
  input  logic [7:0]       op_i,
  output cmd_dec_t         dec_o,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    dec_o = '{kind: KIND_NONE, tgt: TGT_REV};
    len_o = '0;
    case (op_i)
      OP_REV_RD:  begin dec_o = '{kind: KIND_READ,  tgt: TGT_REV};  len_o = LEN_W'(2); end
      OP_CNT_WR:  begin dec_o = '{kind: KIND_WRITE, tgt: TGT_CNT};  len_o = LEN_W'(2); end
      OP_STAT_RD: begin dec_o = '{kind: KIND_READ,  tgt: TGT_STAT}; len_o = LEN_W'(1); end
      OP_CNT_RD:  begin dec_o = '{kind: KIND_READ,  tgt: TGT_CNT};  len_o = LEN_W'(2); end
      OP_TEST_WR: begin dec_o = '{kind: KIND_WRITE, tgt: TGT_TEST}; len_o = LEN_W'(1); end
      OP_TEST_RD: begin dec_o = '{kind: KIND_READ,  tgt: TGT_TEST}; len_o = LEN_W'(1); end
      OP_OPT_WR:  begin dec_o = '{kind: KIND_WRITE, tgt: TGT_OPT};  len_o = LEN_W'(OPT_BYTES); end
      OP_OPT_RD:  begin dec_o = '{kind: KIND_READ,  tgt: TGT_OPT};  len_o = LEN_W'(OPT_BYTES); end
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_cmd_pkg::*;
#(
  parameter int                       OPT_BYTES     = 2,
  parameter int                       IDX_W         = 2,
  parameter logic [OPT_BYTES*8-1:0]   OPT_RESET     = 16'h12C3,
  parameter logic [OPT_BYTES*8-1:0]   OPT_PROT_MASK = 16'h00C0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   debug_mode_i,
  input  logic                   rd_prot_i,
  input  logic                   info_wp_i,
  input  logic                   cnt_we_i,
  input  logic [CNT_W-1:0]       cnt_wdata_i,
  input  logic                   test_we_i,
  input  logic [7:0]             test_wdata_i,
  input  logic                   opt_we_i,
  input  logic [IDX_W-1:0]       opt_idx_i,
  input  logic [7:0]             opt_wdata_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [7:0]             test_o,
  output logic [OPT_BYTES*8-1:0] opt_o,
  output logic [7:0]             status_o
);
  localparam int OPT_W = OPT_BYTES * 8;

  logic [7:0] test_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (cnt_we_i) cnt_o <= cnt_wdata_i;
  end

  // write-protect blocks a 0->1 edge on the enable bit only
  always_comb begin
    test_next = test_wdata_i;
    if (info_wp_i) test_next[TEST_EN] = test_wdata_i[TEST_EN] & test_o[TEST_EN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) test_o <= '0;
    else if (test_we_i) test_o <= test_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else status_o <= {debug_mode_i, rd_prot_i, info_wp_i, test_o[TEST_EN], 4'h0};
  end

  for (genvar g = 0; g < OPT_BYTES; g++) begin : g_opt
    localparam logic [7:0] KEEP = OPT_PROT_MASK[g*8 +: 8];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) opt_o[g*8 +: 8] <= OPT_RESET[g*8 +: 8];
      else if (opt_we_i && opt_idx_i == IDX_W'(g))
        opt_o[g*8 +: 8] <= (opt_wdata_i & ~KEEP) | (opt_o[g*8 +: 8] & KEEP);
    end
  end

  p_test_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (info_wp_i && !test_o[TEST_EN]) |=> !test_o[TEST_EN]);

  p_prot_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_we_i |=> ((opt_o & OPT_PROT_MASK) == $past(opt_o & OPT_PROT_MASK)));

  p_opt_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_we_i |-> (32'(opt_idx_i) < OPT_W / 8));
endmodule

// File: rtl/dbg_resp_build.sv
module dbg_resp_build
  import dbg_cmd_pkg::*;
#(
  parameter int          OPT_BYTES = 2,
  parameter int          RESP_W    = 16,
  parameter logic [15:0] REV_ID    = 16'h0103
) (
  input  cmd_tgt_e               tgt_i,
  input  logic                   debug_mode_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [7:0]             test_i,
  input  logic [OPT_BYTES*8-1:0] opt_i,
  input  logic [7:0]             status_i,
  output logic [RESP_W-1:0]      resp_o
);
  // byte 0 sits in the low lane and leaves first
  always_comb begin
    resp_o = '0;
    case (tgt_i)
      TGT_REV:  resp_o[15:0] = {REV_ID[7:0], REV_ID[15:8]};
      TGT_STAT: resp_o[7:0]  = status_i;
      TGT_CNT:  resp_o[15:0] = debug_mode_i ? {~cnt_i[7:0], ~cnt_i[15:8]} : 16'hFFFF;
      TGT_TEST: resp_o[7:0]  = test_i;
      TGT_OPT:  resp_o[OPT_BYTES*8-1:0] = opt_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_cmd_interp.sv
module dbg_cmd_interp
  import dbg_cmd_pkg::*;
#(
  parameter int                     OPT_BYTES     = 2,
  parameter logic [15:0]            REV_ID        = 16'h0103,
  parameter logic [OPT_BYTES*8-1:0] OPT_RESET     = 16'h12C3,
  parameter logic [OPT_BYTES*8-1:0] OPT_PROT_MASK = 16'h00C0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       debug_mode_i,
  input  logic       rd_prot_i,
  input  logic       info_wp_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  input  logic       out_ready_i
);
  localparam int MAX_LEN = (OPT_BYTES > 2) ? OPT_BYTES : 2;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int RESP_W  = MAX_LEN * 8;
  localparam int OPT_W   = OPT_BYTES * 8;

  cmd_st_e           st_q;
  cmd_tgt_e          tgt_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic              dbg_q;
  logic [7:0]        hold_q;
  logic [RESP_W-1:0] resp_q;

  cmd_dec_t          dec;
  logic [LEN_W-1:0]  dec_len;
  logic [RESP_W-1:0] resp_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        test_q, status_q;
  logic [OPT_W-1:0]  opt_q;

  logic in_fire, out_fire, rx_fire, last;
  logic cnt_we, test_we, opt_we;

  assign in_ready_o  = (st_q != ST_TX);
  assign out_valid_o = (st_q == ST_TX);
  assign out_data_o  = resp_q[7:0];

  assign in_fire  = in_valid_i & in_ready_o;
  assign out_fire = out_valid_o & out_ready_i;
  assign rx_fire  = in_fire && st_q == ST_RX;
  assign last     = (idx_q == len_q - LEN_W'(1));

  assign cnt_we  = rx_fire && tgt_q == TGT_CNT && idx_q == LEN_W'(1) && dbg_q;
  assign test_we = rx_fire && tgt_q == TGT_TEST;
  assign opt_we  = rx_fire && tgt_q == TGT_OPT;

  dbg_cmd_decode #(.OPT_BYTES(OPT_BYTES), .LEN_W(LEN_W)) i_decode (
    .op_i  (in_data_i),
    .dec_o (dec),
    .len_o (dec_len)
  );

  dbg_resp_build #(.OPT_BYTES(OPT_BYTES), .RESP_W(RESP_W), .REV_ID(REV_ID)) i_resp (
    .tgt_i        (dec.tgt),
    .debug_mode_i (debug_mode_i),
    .cnt_i        (cnt_q),
    .test_i       (test_q),
    .opt_i        (opt_q),
    .status_i     (status_q),
    .resp_o       (resp_d)
  );

  dbg_reg_bank #(
    .OPT_BYTES(OPT_BYTES), .IDX_W(LEN_W),
    .OPT_RESET(OPT_RESET), .OPT_PROT_MASK(OPT_PROT_MASK)
  ) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .debug_mode_i (debug_mode_i),
    .rd_prot_i    (rd_prot_i),
    .info_wp_i    (info_wp_i),
    .cnt_we_i     (cnt_we),
    .cnt_wdata_i  ({hold_q, in_data_i}),
    .test_we_i    (test_we),
    .test_wdata_i (in_data_i),
    .opt_we_i     (opt_we),
    .opt_idx_i    (idx_q),
    .opt_wdata_i  (in_data_i),
    .cnt_o        (cnt_q),
    .test_o       (test_q),
    .opt_o        (opt_q),
    .status_o     (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tgt_q  <= TGT_REV;
      len_q  <= '0;
      idx_q  <= '0;
      dbg_q  <= 1'b0;
      hold_q <= '0;
      resp_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (in_fire) begin
          tgt_q <= dec.tgt;
          len_q <= dec_len;
          idx_q <= '0;
          dbg_q <= debug_mode_i;
          if (dec.kind == KIND_READ) begin
            resp_q <= resp_d;
            st_q   <= ST_TX;
          end else if (dec.kind == KIND_WRITE) begin
            st_q <= ST_RX;
          end
        end
        ST_RX: if (in_fire) begin
          if (idx_q == '0) hold_q <= in_data_i;
          idx_q <= idx_q + LEN_W'(1);
          if (last) st_q <= ST_IDLE;
        end
        ST_TX: if (out_fire) begin
          resp_q <= {8'h00, resp_q[RESP_W-1:8]};
          idx_q  <= idx_q + LEN_W'(1);
          if (last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_idx_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (idx_q < len_q));

  p_cnt_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RX && !dbg_q) |=> $stable(cnt_q));

  p_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && in_fire && dec.kind == KIND_NONE) |=>
      (in_ready_o && !out_valid_o && $stable(cnt_q) && $stable(test_q) && $stable(opt_q)));

  p_resp_next_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && in_fire && dec.kind == KIND_READ) |=> out_valid_o);
endmodule

// File: tb/test_dbg_cmd_interp.sv
`timescale 1ns/1ps
module test_dbg_cmd_interp;
  localparam int          OPT_BYTES = 2;
  localparam logic [15:0] REV       = 16'h0103;
  localparam logic [15:0] OPT_RST   = 16'h12C3;
  localparam logic [15:0] PROT      = 16'h00C0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dbg_mode = 1'b1, rd_prot = 1'b0, iwp = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_ready;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  dbg_cmd_interp #(.OPT_BYTES(OPT_BYTES), .REV_ID(REV), .OPT_RESET(OPT_RST), .OPT_PROT_MASK(PROT))
  i_dbg_cmd_interp (
    .clk_i(clk), .rst_ni(rst_ni), .debug_mode_i(dbg_mode), .rd_prot_i(rd_prot),
    .info_wp_i(iwp), .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int    nchecks = 0, nerr = 0;
  string cur_req = "R1 reset";
  bit    done = 1'b0;
  bit    bp = 1'b0;
  int    cyc = 0;

  // behavioural reference
  logic [7:0]  mq[$];
  bit          m_rx;
  int          m_left, m_idx;
  logic [7:0]  m_op, m_hold, m_test, m_status;
  logic        m_dbg;
  logic [15:0] m_cnt;
  logic [7:0]  m_opt[OPT_BYTES];

  always @(posedge clk or negedge rst_ni) begin : model
    logic [7:0] nstat;
    logic [7:0] keep;
    if (!rst_ni) begin
      mq.delete();
      m_rx = 0; m_left = 0; m_idx = 0;
      m_cnt = '0; m_test = '0; m_status = '0;
      for (int i = 0; i < OPT_BYTES; i++) m_opt[i] = OPT_RST[i*8 +: 8];
    end else begin
      nstat = {dbg_mode, rd_prot, iwp, m_test[0], 4'h0};
      if (mq.size() != 0) begin
        if (out_ready) void'(mq.pop_front());
      end else if (in_valid) begin
        if (!m_rx) begin
          m_op = in_data; m_idx = 0; m_dbg = dbg_mode;
          case (in_data)
            8'h00: begin mq.push_back(REV[15:8]); mq.push_back(REV[7:0]); end
            8'h02: mq.push_back(m_status);
            8'h03: begin
              mq.push_back(dbg_mode ? ~m_cnt[15:8] : 8'hFF);
              mq.push_back(dbg_mode ? ~m_cnt[7:0] : 8'hFF);
            end
            8'hF1: mq.push_back(m_test);
            8'hF3: for (int i = 0; i < OPT_BYTES; i++) mq.push_back(m_opt[i]);
            8'h01: begin m_rx = 1; m_left = 2; end
            8'hF0: begin m_rx = 1; m_left = 1; end
            8'hF2: begin m_rx = 1; m_left = OPT_BYTES; end
            default: ;
          endcase
        end else begin
          case (m_op)
            8'h01: if (m_idx == 0) m_hold = in_data;
                   else if (m_dbg) m_cnt = {m_hold, in_data};
            8'hF0: m_test = iwp ? {in_data[7:1], in_data[0] & m_test[0]} : in_data;
            8'hF2: begin
              keep = PROT[m_idx*8 +: 8];
              m_opt[m_idx] = (in_data & ~keep) | (m_opt[m_idx] & keep);
            end
            default: ;
          endcase
          m_idx++;
          if (m_idx == m_left) m_rx = 0;
        end
      end
      m_status = nstat;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    out_ready = bp ? (cyc % 3 != 0) : 1'b1;
    if (rst_ni && !done) begin
      logic       e_valid;
      logic [7:0] e_data;
      e_valid = (mq.size() != 0);
      e_data  = e_valid ? mq[0] : 8'h00;
      nchecks++;
      if (in_ready !== !e_valid || out_valid !== e_valid || (e_valid && out_data !== e_data)) begin
        nerr++;
        $display("FAIL %s: in_ready=%0b out_valid=%0b data=%02h expected in_ready=%0b out_valid=%0b data=%02h",
                 cur_req, in_ready, out_valid, out_data, !e_valid, e_valid, e_data);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (out_valid || !in_ready) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    send(op); drain();
  endtask

  task automatic cmd2(input logic [7:0] op, input logic [7:0] a);
    send(op); send(a); drain();
  endtask

  task automatic cmd3(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    send(op); send(a); send(b); drain();
  endtask

  task automatic read_all();
    cmd1(8'h03); cmd1(8'hF1); cmd1(8'hF3); cmd1(8'h02);
  endtask

  initial begin
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cur_req = "R1 reset values";
    read_all();

    cur_req = "R2 revision";
    cmd1(8'h00);

    cur_req = "R3 counter write in debug";
    cmd3(8'h01, 8'h12, 8'h34); cmd1(8'h03);
    dbg_mode = 1'b0;
    cur_req = "R3 counter write dropped";
    cmd3(8'h01, 8'hAA, 8'hBB);
    dbg_mode = 1'b1;
    cmd1(8'h03);

    cur_req = "R5 counter read outside debug";
    dbg_mode = 1'b0; cmd1(8'h03);
    dbg_mode = 1'b1; cmd3(8'h01, 8'h00, 8'h00); cmd1(8'h03);
    cmd3(8'h01, 8'hFF, 8'h0F); cmd1(8'h03);

    cur_req = "R4 status";
    rd_prot = 1'b1; iwp = 1'b1; @(negedge clk); cmd1(8'h02);
    rd_prot = 1'b0; dbg_mode = 1'b0; @(negedge clk); cmd1(8'h02);
    dbg_mode = 1'b1; iwp = 1'b0; cmd1(8'h02);

    cur_req = "R6 test register";
    cmd2(8'hF0, 8'h01); cmd1(8'hF1); cmd1(8'h02);
    iwp = 1'b1;
    cmd2(8'hF0, 8'h00); cmd1(8'hF1);
    cmd2(8'hF0, 8'hA5); cmd1(8'hF1);
    iwp = 1'b0;
    cmd2(8'hF0, 8'h5B); cmd1(8'hF1);
    iwp = 1'b1; cmd2(8'hF0, 8'h3C); cmd1(8'hF1);
    iwp = 1'b0;

    cur_req = "R7 option bytes";
    cmd3(8'hF2, 8'h00, 8'h5A); cmd1(8'hF3);
    cmd3(8'hF2, 8'hFF, 8'hA7); cmd1(8'hF3);

    cur_req = "R8 reserved opcodes";
    cmd1(8'h55); cmd1(8'h7E); cmd1(8'hFF); cmd1(8'h04); cmd1(8'hF4);
    read_all();

    cur_req = "R9 backpressure";
    bp = 1'b1;
    cmd1(8'h00); cmd1(8'h03); cmd1(8'hF3); cmd1(8'h02);
    cmd3(8'h01, 8'h9A, 8'hBC); cmd1(8'h03);
    bp = 1'b0;

    cur_req = "R10 back-to-back";
    send(8'hF0); send(8'h06); send(8'hF1); send(8'h01); send(8'h11); send(8'h22);
    send(8'h03); drain();
    send(8'hF2); send(8'h3F); send(8'h44); send(8'hF3); drain();

    cur_req = "R1 mid-run reset";
    cmd2(8'hF0, 8'h0E);
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    read_all();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog in %s: run did not finish, expected completion", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule